// File: doc/BRIEF.md
# 100BASE-TX 4B/5B Coding Stage

This block performs the symbol coding layer of a Fast Ethernet physical coding sublayer. On the transmit side, it takes one nibble per clock from a media independent interface, together with its enable and error strobes. It produces one 5-bit code group per clock. At the start of every frame it puts the two-symbol start delimiter in place of the first two nibbles. When the enable drops, it appends the two-symbol end delimiter. Between frames it sends the idle group, and while a transmit error is flagged it sends the halt group.

The receive side takes 5-bit code groups that are already aligned on group boundaries. It watches for the start delimiter pair to begin a frame. Inside a frame it turns data groups back into nibbles with a valid strobe. The end delimiter closes the frame. Illegal groups, a broken start delimiter, a broken end delimiter and an idle that arrives inside a frame are all reported on the receive error output. Both directions register their outputs, so each output follows its input by one clock. Scrambling and line coding sit outside this block.

Top module: `pcs_4b5b_coder`

## Requirements
- R1: While rst_ni is low, tx_code_o is 11111, and rx_dv_o, rx_er_o and rxd_o are all 0.
- R2: In a frame body (from the third enabled cycle on), a nibble with tx_er_i low appears on tx_code_o one clock later. The nibble values 0..F give 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101 in that order.
- R3: The first enabled cycle after idle emits J (11000), and the next cycle emits K (10001), whatever tx_en_i is in that second cycle. The nibbles presented in those cycles are discarded.
- R4: The first cycle in the body with tx_en_i low emits T (01101). The next cycle emits R (00111) whatever the inputs are. After that the output is idle (11111) until tx_en_i is high in an idle cycle.
- R5: In the body, tx_en_i and tx_er_i both high emit H (00100) in place of the data group.
- R6: While idle with tx_en_i low, txd_i and tx_er_i have no effect: tx_code_o stays 11111.
- R7: After J (11000) is followed directly by K (10001) on rx_code_i, each following data group gives rx_dv_o=1 and rxd_o=its nibble (same table as R2) one clock later. Outside a frame, rx_dv_o=0 and rxd_o=0.
- R8: T (01101) inside a frame gives rx_dv_o=0 one clock later. If the group after T is not R (00111), rx_er_o pulses for one cycle. In either case the receiver then hunts for J again.
- R9: A group that is not a data group, T or idle inside a frame gives rx_dv_o=1, rx_er_o=1 and rxd_o=0, and the frame continues. This includes 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000, 11001 and H.
- R10: J followed by any group other than K gives a one-cycle rx_er_o with rx_dv_o=0, and the receiver hunts again.
- R11: Idle (11111) inside a frame ends the frame with rx_er_o=1 and rx_dv_o=0 for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one code group per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 4 | Transmit nibble |
| tx_en_i | input | 1 | Transmit enable |
| tx_er_i | input | 1 | Transmit error |
| tx_code_o | output | 5 | Transmit code group |
| rx_code_i | input | 5 | Received aligned code group |
| rxd_o | output | 4 | Received nibble |
| rx_dv_o | output | 1 | Received data valid |
| rx_er_o | output | 1 | Receive error |

## Verification
Transmit stimulus is a mix of random frames, random gap lengths and random error strobes. The directed part covers one-nibble and two-nibble frames, which separate the delimiter pair from the body. One-cycle gaps check that the R slot swallows a new enable instead of starting a frame. Errors raised while idle show that they are ignored. The receive stream comes from a weighted generator that follows the frame state. It mostly builds legal frames, and at random it injects lone J groups, illegal groups, idle inside a frame and a missing R, so that each error path is separated from the normal end of a frame.

// File: rtl/pcs4b5b_pkg.sv
package pcs4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;
  typedef logic [CG_W-1:0]  cg_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND_K, TX_BODY, TX_SEND_R} tx_st_e;
  typedef enum logic [1:0] {RX_HUNT, RX_SAW_J, RX_FRAME, RX_SAW_T} rx_st_e;

  function automatic cg_t nib_to_cg(nib_t n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  // returns {hit, nibble}
  function automatic logic [NIB_W:0] cg_to_nib(cg_t c);
    case (c)
      5'b11110: return 5'h10;  5'b01001: return 5'h11;
      5'b10100: return 5'h12;  5'b10101: return 5'h13;
      5'b01010: return 5'h14;  5'b01011: return 5'h15;
      5'b01110: return 5'h16;  5'b01111: return 5'h17;
      5'b10010: return 5'h18;  5'b10011: return 5'h19;
      5'b10110: return 5'h1A;  5'b10111: return 5'h1B;
      5'b11010: return 5'h1C;  5'b11011: return 5'h1D;
      5'b11100: return 5'h1E;  5'b11101: return 5'h1F;
      default:  return 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/pcs_tx_enc.sv
module pcs_tx_enc
  import pcs4b5b_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  nib_t txd_i,
  input  logic tx_en_i,
  input  logic tx_er_i,
  output cg_t  code_o
);
  tx_st_e st_q, st_d;
  cg_t    code_q, code_d;

  always_comb begin
    st_d   = st_q;
    code_d = CG_IDLE;
    case (st_q)
      TX_IDLE: if (tx_en_i) begin
        code_d = CG_J;
        st_d   = TX_SEND_K;
      end
      TX_SEND_K: begin
        code_d = CG_K;
        st_d   = TX_BODY;
      end
      TX_BODY: if (tx_en_i) begin
        code_d = tx_er_i ? CG_H : nib_to_cg(txd_i);
      end else begin
        code_d = CG_T;
        st_d   = TX_SEND_R;
      end
      default: begin
        code_d = CG_R;
        st_d   = TX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      code_q <= CG_IDLE;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

  AST_START_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_IDLE && tx_en_i) |=> code_o == CG_J); // R3
  AST_J_THEN_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_J) |=> code_o == CG_K); // R3
  AST_T_THEN_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_T) |=> code_o == CG_R); // R4
  AST_HALT_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_BODY && tx_en_i && tx_er_i) |=> code_o == CG_H); // R5
endmodule

// File: rtl/pcs_rx_dec.sv
module pcs_rx_dec
  import pcs4b5b_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cg_t  code_i,
  output nib_t rxd_o,
  output logic rx_dv_o,
  output logic rx_er_o
);
  rx_st_e st_q, st_d;
  nib_t   nib_q, nib_d;
  logic   dv_q, dv_d, er_q, er_d;
  logic [NIB_W:0] dec;

  assign dec = cg_to_nib(code_i);

  always_comb begin
    st_d  = st_q;
    nib_d = '0;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    case (st_q)
      RX_HUNT: if (code_i == CG_J) st_d = RX_SAW_J;
      RX_SAW_J: if (code_i == CG_K) st_d = RX_FRAME;
        else begin
          er_d = 1'b1;
          st_d = RX_HUNT;
        end
      RX_FRAME: if (code_i == CG_T) st_d = RX_SAW_T;
        else if (code_i == CG_IDLE) begin
          er_d = 1'b1;
          st_d = RX_HUNT;
        end else if (dec[NIB_W]) begin
          dv_d  = 1'b1;
          nib_d = dec[NIB_W-1:0];
        end else begin
          dv_d = 1'b1;
          er_d = 1'b1;
        end
      default: begin
        st_d = RX_HUNT;
        er_d = (code_i != CG_R);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_HUNT;
      nib_q <= '0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      nib_q <= nib_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
    end
  end

  assign rxd_o   = nib_q;
  assign rx_dv_o = dv_q;
  assign rx_er_o = er_q;

  AST_DV_AFTER_JK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> $past(code_i, 2) == CG_K); // R7
  AST_T_DROPS_DV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_FRAME && code_i == CG_T) |=> !rx_dv_o); // R8
  AST_IDLE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_FRAME && code_i == CG_IDLE) |=> (rx_er_o && !rx_dv_o)); // R11
  AST_LONE_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_SAW_J && code_i != CG_K) |=> (rx_er_o && !rx_dv_o)); // R10
endmodule

// File: rtl/pcs_4b5b_coder.sv
module pcs_4b5b_coder
  import pcs4b5b_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] txd_i,
  input  logic       tx_en_i,
  input  logic       tx_er_i,
  output logic [4:0] tx_code_o,
  input  logic [4:0] rx_code_i,
  output logic [3:0] rxd_o,
  output logic       rx_dv_o,
  output logic       rx_er_o
);
  pcs_tx_enc u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .txd_i   (txd_i),
    .tx_en_i (tx_en_i),
    .tx_er_i (tx_er_i),
    .code_o  (tx_code_o)
  );

  pcs_rx_dec u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .code_i  (rx_code_i),
    .rxd_o   (rxd_o),
    .rx_dv_o (rx_dv_o),
    .rx_er_o (rx_er_o)
  );
endmodule

// File: tb/pcs_4b5b_coder_tb.sv
module pcs_4b5b_coder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] txd = '0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [4:0] tx_code;
  logic [4:0] rx_code = 5'b11111;
  logic [3:0] rxd;
  logic       rx_dv, rx_er;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [4:0] ENC [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
    5'b01010, 5'b01011, 5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110,
    5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
  localparam logic [4:0] BAD [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
    5'b00101, 5'b00110, 5'b01000, 5'b01100, 5'b10000, 5'b11001, 5'b00100};

  always #2 clk = ~clk;

  pcs_4b5b_coder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .tx_en_i(tx_en), .tx_er_i(tx_er),
    .tx_code_o(tx_code), .rx_code_i(rx_code), .rxd_o(rxd), .rx_dv_o(rx_dv),
    .rx_er_o(rx_er)
  );

  // bench models
  int m_tx = 0, m_rx = 0;
  logic [4:0] exp_tx = 5'b11111;
  logic       exp_dv = 1'b0, exp_er = 1'b0;
  logic [3:0] exp_rxd = '0;
  string tx_tag = "R1", rx_tag = "R1";

  function automatic int lookup(logic [4:0] c);
    for (int i = 0; i < 16; i++) if (ENC[i] == c) return i;
    return -1;
  endfunction

  task automatic tx_model(logic en, logic er, logic [3:0] d);
    case (m_tx)
      0: if (en) begin exp_tx = 5'b11000; tx_tag = "R3"; m_tx = 1; end
         else begin exp_tx = 5'b11111; tx_tag = "R6"; end
      1: begin exp_tx = 5'b10001; tx_tag = "R3"; m_tx = 2; end
      2: if (!en) begin exp_tx = 5'b01101; tx_tag = "R4"; m_tx = 3; end
         else if (er) begin exp_tx = 5'b00100; tx_tag = "R5"; end
         else begin exp_tx = ENC[d]; tx_tag = "R2"; end
      default: begin exp_tx = 5'b00111; tx_tag = "R4"; m_tx = 0; end
    endcase
  endtask

  task automatic rx_model(logic [4:0] c);
    int n;
    n = lookup(c);
    exp_dv = 0; exp_er = 0; exp_rxd = 0; rx_tag = "R7";
    case (m_rx)
      0: if (c == 5'b11000) m_rx = 1;
      1: if (c == 5'b10001) m_rx = 2;
         else begin exp_er = 1; rx_tag = "R10"; m_rx = 0; end
      2: if (c == 5'b01101) begin rx_tag = "R8"; m_rx = 3; end
         else if (c == 5'b11111) begin exp_er = 1; rx_tag = "R11"; m_rx = 0; end
         else if (n >= 0) begin exp_dv = 1; exp_rxd = 4'(n); end
         else begin exp_dv = 1; exp_er = 1; rx_tag = "R9"; end
      default: begin exp_er = (c != 5'b00111); rx_tag = "R8"; m_rx = 0; end
    endcase
  endtask

  task automatic compare();
    checks++;
    if (tx_code !== exp_tx) begin
      errors++;
      $display("FAIL %s tx_code actual=%b expected=%b", tx_tag, tx_code, exp_tx);
    end
    checks++;
    if ({rx_dv, rx_er, rxd} !== {exp_dv, exp_er, exp_rxd}) begin
      errors++;
      $display("FAIL %s rx dv/er/rxd actual=%b/%b/%h expected=%b/%b/%h",
               rx_tag, rx_dv, rx_er, rxd, exp_dv, exp_er, exp_rxd);
    end
  endtask

  // one clock: check the previous step's result, then apply new inputs
  task automatic step(logic en, logic er, logic [3:0] d, logic [4:0] c);
    @(negedge clk);
    compare();
    txd = d; tx_en = en; tx_er = er; rx_code = c;
    tx_model(en, er, d);
    rx_model(c);
  endtask

  function automatic logic [4:0] pick_rx();
    int r;
    r = $urandom_range(99, 0);
    case (m_rx)
      0: return (r < 35) ? 5'b11000 : ((r < 45) ? BAD[$urandom_range(10, 0)] : 5'b11111);
      1: return (r < 85) ? 5'b10001 : ((r < 92) ? 5'b11111 : ENC[$urandom_range(15, 0)]);
      2: if (r < 80) return ENC[$urandom_range(15, 0)];
         else if (r < 88) return 5'b01101;
         else if (r < 93) return 5'b11111;
         else return BAD[$urandom_range(10, 0)];
      default: return (r < 85) ? 5'b00111 : ENC[$urandom_range(15, 0)];
    endcase
  endfunction

  initial begin
    int len, gap;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1: reset state
    tx_tag = "R1"; rx_tag = "R1";
    compare();
    rst_n = 1'b1;
    // directed transmit corner cases, receive: a clean frame J K 3 A T R
    step(0, 1, 4'h9, 5'b11111);            // R6 error while idle
    step(1, 0, 4'h1, 5'b11000);            // J
    step(0, 0, 4'h2, 5'b10001);            // one-nibble frame R3, K
    step(0, 0, 4'h0, ENC[3]);              // T R4
    step(1, 0, 4'h5, ENC[10]);             // R slot ignores enable R4
    step(1, 0, 4'h5, 5'b01101);            // J again
    step(1, 0, 4'h6, 5'b00111);            // K
    step(1, 1, 4'h7, 5'b11111);            // H R5
    step(1, 0, 4'hF, 5'b11000);            // data F R2
    step(0, 0, 4'h0, 5'b00100);            // lone J R10
    step(0, 1, 4'h3, 5'b11111);
    step(0, 1, 4'h3, 5'b11111);            // R6 idle after R
    // random
    for (int f = 0; f < 400; f++) begin
      len = $urandom_range(12, 1);
      gap = $urandom_range(4, 1);
      for (int i = 0; i < len; i++)
        step(1, ($urandom_range(9, 0) == 0), 4'($urandom), pick_rx());
      for (int i = 0; i < gap; i++)
        step(0, 1'($urandom), 4'($urandom), pick_rx());
    end
    step(0, 0, 4'h0, 5'b11111);
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule